// File: doc/BRIEF.md
# Machine-Check Interrupt Mask Controller

This block gathers one-cycle reports of machine-check conditions and decides, for each one, whether the processor takes a machine-check interruption, enters the check-stop state, or keeps the condition pending. Six condition types are handled. Two are exigent: system damage and instruction-processing damage. Four are repressible: recovery, degradation, external damage and warning. A master machine-check enable bit from the program status word gates every interruption. A 32-bit subclass-mask control register adds a second, per-type gate for the repressible types.

Every report is held in a sticky pending bit. A small state machine has three states. It stays in RUN while nothing is enabled. It goes from RUN to PRESENT when the master enable is on and at least one pending condition is enabled. It goes from RUN to STOP when an exigent condition is pending while the master enable is off. PRESENT lasts one cycle and always returns to RUN. During that cycle, the interrupt request is high and every pending condition is shown, enabled or not. Those conditions are then cleared. STOP is left only by reset.

Top module: `mck_mask_ctrl`

## Requirements
- R1: After reset, `cr_o` reads 32'h8200_0000. Register bit 31 (program bit 0) and register bit 25 (external-damage mask) are one. `irq_o`, `present_o` and `chkstop_o` are zero.
- R2: A write with `cr_wr_en` high stores register bits 31 and 27..24 from `cr_wr_data`, and `cr_o` shows them after the next clock edge. All other bits of `cr_o` read zero. Register bit 31 has no effect on interruptions.
- R3: Condition bit 0 (system damage) and bit 1 (instruction-processing damage) are exigent. With `mck_en_i` high, a pulse of either one raises `irq_o` in the second cycle after the pulse edge, whatever the subclass masks hold.
- R4: Repressible condition bits map to subclass masks as follows: bit 2 recovery to register bit 27, bit 3 degradation to bit 26, bit 4 external damage to bit 25, and bit 5 warning to bit 24. Such a condition interrupts only when `mck_en_i` is high and its mask bit is one.
- R5: A repressible condition whose mask bit is zero raises no request and stays pending. Setting its mask bit later raises `irq_o` in the second cycle after the write edge.
- R6: `irq_o` is high for exactly one cycle. In that cycle, `present_o` holds every pending condition, including ones that are not enabled. `present_o` is zero whenever `irq_o` is low.
- R7: Conditions shown with a request are cleared after the request cycle. A condition pulsed during the request cycle is kept pending.
- R8: An exigent condition pending while `mck_en_i` is low sets `chkstop_o` in the second cycle after the pulse edge, with no request.
- R9: Once `chkstop_o` is set, it stays set and `irq_o` stays low until reset.
- R10: With `mck_en_i` low, enabled repressible conditions raise no request and stay pending until `mck_en_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mck_en_i | input | 1 | Master machine-check enable from the status word |
| cr_wr_en | input | 1 | Subclass-mask register write strobe |
| cr_wr_data | input | 32 | Subclass-mask register write data |
| cond_pulse_i | input | 6 | One-cycle condition reports (bit 0 system damage … bit 5 warning) |
| irq_o | output | 1 | Machine-check interruption request, one cycle |
| present_o | output | 6 | Conditions presented with the request |
| chkstop_o | output | 1 | Check-stop state |
| cr_o | output | 32 | Current subclass-mask register contents |

## Verification
A pending bit stuck at one would show up as a second request two cycles after the first. A pending bit that fails to set would show up as a missing request once its mask opens. Both appear at `irq_o` within two cycles of the stimulus. A wrong mask bit position shows at `cr_o` immediately after the write, and it also shows as a request that should or should not happen two cycles later. A state machine that leaves STOP, or that stays in PRESENT, gives a request during check-stop or a request wider than one cycle. Either one is visible at the next sample.

// File: rtl/mck_pkg.sv
package mck_pkg;
    localparam int NUM_COND  = 6;
    localparam int NUM_EXIG  = 2;
    localparam int NUM_SUB   = NUM_COND - NUM_EXIG;
    localparam int CR_W      = 32;
    // program bit n lives at register bit CR_W-1-n
    localparam int PBIT_TAG  = 0;
    localparam int PBIT_SUB0 = 4;

    localparam int COND_SYS  = 0;
    localparam int COND_IPD  = 1;
    localparam int COND_RCV  = 2;
    localparam int COND_DEG  = 3;
    localparam int COND_EXT  = 4;
    localparam int COND_WRN  = 5;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_PRESENT = 2'd1,
        ST_STOP    = 2'd2
    } mck_state_t;

    function automatic int reg_pos(input int pbit);
        return CR_W - 1 - pbit;
    endfunction
endpackage

// File: rtl/mck_ctlreg.sv
module mck_ctlreg
    import mck_pkg::*;
#(
    parameter int W      = CR_W,
    parameter int NSUB   = NUM_SUB,
    parameter logic [NSUB-1:0] SUB_RST = 4'b0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_data,
    output logic [W-1:0]    cr_o,
    output logic [NSUB-1:0] sub_mask
);
    localparam int TAG_POS = W - 1 - PBIT_TAG;

    logic            tag_q;
    logic [NSUB-1:0] sub_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= 1'b1;
            sub_q <= SUB_RST;
        end else if (wr_en) begin
            tag_q <= wr_data[TAG_POS];
            for (int i = 0; i < NSUB; i++) begin
                sub_q[i] <= wr_data[W - 1 - PBIT_SUB0 - i];
            end
        end
    end

    always_comb begin
        cr_o          = '0;
        cr_o[TAG_POS] = tag_q;
        for (int i = 0; i < NSUB; i++) begin
            cr_o[W - 1 - PBIT_SUB0 - i] = sub_q[i];
        end
    end

    assign sub_mask = sub_q;

    // R2: register follows the write data one edge later
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sub_mask[0] == $past(wr_data[W-1-PBIT_SUB0])));
endmodule

// File: rtl/mck_pending.sv
module mck_pending
    import mck_pkg::*;
#(
    parameter int N = NUM_COND
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q[g] <= 1'b0;
                end else if (set_i[g]) begin
                    pend_q[g] <= 1'b1;
                end else if (clr_i[g]) begin
                    pend_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

    assign pend_o = pend_q;

    // R7: cleared bits drop unless re-reported on the same edge
    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
    // R5: a report is never lost
    p_set_sticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/mck_fsm.sv
module mck_fsm
    import mck_pkg::*;
#(
    parameter int N  = NUM_COND,
    parameter int NE = NUM_EXIG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mck_en_i,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] enable_i,
    output logic         irq_o,
    output logic [N-1:0] present_o,
    output logic         chkstop_o,
    output logic [N-1:0] clr_o
);
    mck_state_t   state_q, state_d;
    logic [N-1:0] snap_q;
    logic         take_irq;
    logic         go_stop;

    assign take_irq = mck_en_i && ((pend_i & enable_i) != '0);
    assign go_stop  = !mck_en_i && (pend_i[NE-1:0] != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (go_stop)       state_d = ST_STOP;
                else if (take_irq) state_d = ST_PRESENT;
            end
            ST_PRESENT: state_d = ST_RUN;
            ST_STOP:    state_d = ST_STOP;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && state_d == ST_PRESENT) begin
                snap_q <= pend_i;
            end
        end
    end

    always_comb begin
        irq_o     = 1'b0;
        present_o = '0;
        chkstop_o = 1'b0;
        clr_o     = '0;
        unique case (state_q)
            ST_RUN: ;
            ST_PRESENT: begin
                irq_o     = 1'b1;
                present_o = snap_q;
                clr_o     = snap_q;
            end
            ST_STOP: chkstop_o = 1'b1;
            default: ;
        endcase
    end

    p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    p_present_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (present_o != '0));
    p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mck_en_i));
    p_stop_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop_o |=> chkstop_o);
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop_o |-> !irq_o);
endmodule

// File: rtl/mck_mask_ctrl.sv
module mck_mask_ctrl
    import mck_pkg::*;
#(
    parameter int NCOND = NUM_COND,
    parameter int NEXIG = NUM_EXIG,
    parameter int CRW   = CR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mck_en_i,
    input  logic             cr_wr_en,
    input  logic [CRW-1:0]   cr_wr_data,
    input  logic [NCOND-1:0] cond_pulse_i,
    output logic             irq_o,
    output logic [NCOND-1:0] present_o,
    output logic             chkstop_o,
    output logic [CRW-1:0]   cr_o
);
    localparam int NSUB = NCOND - NEXIG;

    logic [NSUB-1:0]  sub_mask;
    logic [NCOND-1:0] pend;
    logic [NCOND-1:0] clr;
    logic [NCOND-1:0] enable;

    assign enable = {sub_mask, {NEXIG{1'b1}}};

    mck_ctlreg #(.W(CRW), .NSUB(NSUB)) u_ctlreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cr_wr_en),
        .wr_data  (cr_wr_data),
        .cr_o     (cr_o),
        .sub_mask (sub_mask)
    );

    mck_pending #(.N(NCOND)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cond_pulse_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    mck_fsm #(.N(NCOND), .NE(NEXIG)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mck_en_i  (mck_en_i),
        .pend_i    (pend),
        .enable_i  (enable),
        .irq_o     (irq_o),
        .present_o (present_o),
        .chkstop_o (chkstop_o),
        .clr_o     (clr)
    );

    // R6: presented vector is quiet outside a request
    p_present_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (present_o == '0));
endmodule

// File: tb/mck_mask_ctrl_bench.sv
module mck_mask_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mck_en;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [5:0]  cond;
    logic        irq;
    logic [5:0]  present;
    logic        chkstop;
    logic [31:0] cr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mck_mask_ctrl u_mck_mask_ctrl (
        .clk(clk), .rst_n(rst_n), .mck_en_i(mck_en),
        .cr_wr_en(wr_en), .cr_wr_data(wr_data), .cond_pulse_i(cond),
        .irq_o(irq), .present_o(present), .chkstop_o(chkstop), .cr_o(cr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mck_en = 1'b1; wr_en = 1'b0; wr_data = '0; cond = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_cr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] m);
        @(negedge clk); cond = m;
        @(negedge clk); cond = '0;
    endtask

    // sample the cycle in which a decision made after a pulse/write shows
    task automatic expect_irq(input string req, input logic [5:0] exp_p);
        @(negedge clk);
        chk(req, {31'd0, irq}, 32'd1);
        chk(req, {26'd0, present}, {26'd0, exp_p});
        @(negedge clk);
        chk(req, {31'd0, irq}, 32'd0);
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
        chk(req, {31'd0, seen}, 32'd0);
    endtask

    task automatic t_reset_r1();
        do_reset();
        chk("R1 cr", cr, 32'h8200_0000);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 chkstop", {31'd0, chkstop}, 32'd0);
        chk("R1 present", {26'd0, present}, 32'd0);
    endtask

    task automatic t_write_r2();
        do_reset();
        write_cr(32'hFFFF_FFFF);
        chk("R2 all ones", cr, 32'h8F00_0000);
        write_cr(32'h0000_0000);
        chk("R2 zeros", cr, 32'h0000_0000);
        // bit 31 alone opens nothing
        write_cr(32'h8000_0000);
        pulse(6'b111100);
        expect_quiet("R2 tag ignored", 4);
    endtask

    task automatic t_exigent_r3();
        do_reset();
        write_cr(32'h0000_0000);
        pulse(6'b000001);
        expect_irq("R3 system damage", 6'b000001);
        pulse(6'b000010);
        expect_irq("R3 instr damage", 6'b000010);
        expect_quiet("R7 no repeat", 3);
    endtask

    task automatic t_repress_r4();
        do_reset();
        write_cr(32'h0800_0000);
        pulse(6'b000100);
        expect_irq("R4 recovery", 6'b000100);
        write_cr(32'h0400_0000);
        pulse(6'b001000);
        expect_irq("R4 degradation", 6'b001000);
        write_cr(32'h0100_0000);
        pulse(6'b100000);
        expect_irq("R4 warning", 6'b100000);
        do_reset();
        pulse(6'b010000);
        expect_irq("R4 external default", 6'b010000);
    endtask

    task automatic t_pending_r5();
        do_reset();
        pulse(6'b100000);
        expect_quiet("R5 masked warning", 5);
        write_cr(32'h0100_0000);
        expect_irq("R5 later enable", 6'b100000);
    endtask

    task automatic t_present_r6_r7();
        do_reset();
        write_cr(32'h0000_0000);
        pulse(6'b000100);
        expect_quiet("R5 masked recovery", 2);
        pulse(6'b000001);
        @(negedge clk);
        chk("R6 irq", {31'd0, irq}, 32'd1);
        chk("R6 presents masked", {26'd0, present}, 32'b000101);
        cond = 6'b001000;               // arrives during request cycle
        @(negedge clk);
        cond = '0;
        chk("R6 one cycle", {31'd0, irq}, 32'd0);
        chk("R6 present quiet", {26'd0, present}, 32'd0);
        write_cr(32'h0800_0000);        // recovery was cleared
        expect_quiet("R7 cleared", 3);
        write_cr(32'h0400_0000);        // degradation still pending
        expect_irq("R7 kept late pulse", 6'b001000);
    endtask

    task automatic t_master_r10();
        do_reset();
        write_cr(32'h0F00_0000);
        mck_en = 1'b0;
        pulse(6'b001100);
        expect_quiet("R10 master off", 4);
        chk("R10 no stop", {31'd0, chkstop}, 32'd0);
        mck_en = 1'b1;
        expect_irq("R10 master on", 6'b001100);
    endtask

    task automatic t_stop_r8_r9();
        do_reset();
        mck_en = 1'b0;
        pulse(6'b000010);
        @(negedge clk);
        chk("R8 stop", {31'd0, chkstop}, 32'd1);
        chk("R8 no irq", {31'd0, irq}, 32'd0);
        mck_en = 1'b1;
        pulse(6'b010001);
        expect_quiet("R9 silent", 5);
        chk("R9 sticky", {31'd0, chkstop}, 32'd1);
        do_reset();
        chk("R9 reset clears", {31'd0, chkstop}, 32'd0);
    endtask

    initial begin
        t_reset_r1();
        t_write_r2();
        t_exigent_r3();
        t_repress_r4();
        t_pending_r5();
        t_present_r6_r7();
        t_master_r10();
        t_stop_r8_r9();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule